// File: doc/BRIEF.md
# Microcode Bus Former and Branch Modifier

This block sits at the centre of a horizontally microcoded datapath. Each cycle it takes the decoded fields of the current microinstruction and builds the 16-bit processor bus from them. The sources it can select are the register file, memory data, an auxiliary source and a built-in table of constants. The bus behaves as a wired-AND: a source that is not driven reads as ones, and a constant gated together with another source masks that source.

The block also holds the T, L and M working registers and a latched ALU carry. It turns the branch functions of the second special-function field into an address modifier. That modifier is registered and ORed into the NEXT field of the following microinstruction to form the micro-address. The ALU, the shifter and the memory controller are outside the block: their results arrive as inputs.

A stall input freezes every register for one cycle while memory is not ready.

Top module: `mcb_bus_branch`

## Requirements
- R1: With neither special field set to the constant code (7), the bus is set by the source selector: 0 gives register data, 1 gives all zeros, 2 gives all ones, 3 gives the auxiliary input and 4 gives memory data.
- R2: The constant table word at address a = {rsel[4:0], bs[2:0]} is {a, ~a} XOR the seed (default 16'h3C5A). When f1 or f2 equals 7, the bus carries that word alone, whatever bs is.
- R3: For source selector 5, 6 or 7 with no constant code, the bus is the auxiliary input ANDed with the constant word.
- R4: When the select override is enabled, the register address is {rsel[4:2], rsel_alt}; otherwise it is rsel. The constant table address always uses the raw rsel.
- R5: For f2 codes 1 (bus zero), 2 (shifter negative) and 3 (shifter zero), modifier bit 0 is set on the next cycle when the condition holds, and the modifier is 0 otherwise.
- R6: f2 code 4 loads the low 10 bits of the bus into the modifier for the next cycle.
- R7: The carry register changes only on a cycle that loads L, and then takes alu_cout. f2 code 5 puts the registered carry, not the current alu_cout, into modifier bit 0.
- R8: A cycle that loads L writes alu_res into both L and M.
- R9: A cycle that loads T writes alu_res when the ALU function is 0, 2, 5, 6, 10, 11 or 12, and writes the bus otherwise.
- R10: The micro-address is next_fld ORed with the registered modifier. Every unstalled cycle replaces the modifier, so it is 0 after a cycle with no branch function.
- R11: Synchronous reset clears T, L, M, the carry and the modifier.
- R12: During a stall cycle T, L, M, the carry and the modifier keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Memory not ready; hold all state this cycle |
| bs | input | 3 | Bus source selector |
| f1 | input | 4 | First special-function field |
| f2 | input | 4 | Second special-function field |
| rsel | input | 5 | Register select field |
| rsel_alt_en | input | 1 | Replace the low two select bits |
| rsel_alt | input | 2 | Replacement low select bits |
| aluf | input | 4 | ALU function field |
| ld_t | input | 1 | Load T this cycle |
| ld_l | input | 1 | Load L and M this cycle |
| next_fld | input | 10 | NEXT field of the current microinstruction |
| rf_data | input | 16 | Register file read data |
| md_data | input | 16 | Memory data |
| aux_data | input | 16 | Auxiliary bus source |
| alu_res | input | 16 | ALU result for the current bus and T |
| alu_cout | input | 1 | ALU carry out |
| shift_res | input | 16 | Shifter result computed from L |
| rf_addr | output | 5 | Effective register address |
| bus | output | 16 | Processor bus |
| upc | output | 10 | Micro-address of this instruction |
| t_q | output | 16 | T register |
| l_q | output | 16 | L register |
| m_q | output | 16 | M register |
| carry_q | output | 1 | Carry latched by the last L load |
| mod_q | output | 10 | Registered address modifier |

## Verification
Some results appear in the same cycle as the stimulus. The bus and the register address follow their inputs combinationally, and so does the micro-address given the modifier already held. The bench samples these one nanosecond after driving inputs on the falling edge. The T, L, M and carry registers and the modifier change one rising edge after the cycle that computes them. The bench's model therefore updates its own state only at that edge, and compares the registers on the next falling edge. Each register check is tagged with the requirement its previous cycle exercised: stall, branch kind or load.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  localparam int DW  = 16;
  localparam int NW  = 10;
  localparam int RSW = 5;
  localparam int BSW = 3;
  localparam int AW  = RSW + BSW;

  localparam logic [3:0] FN_CONST   = 4'd7;
  localparam logic [3:0] BR_BUSZERO = 4'd1;
  localparam logic [3:0] BR_SHNEG   = 4'd2;
  localparam logic [3:0] BR_SHZERO  = 4'd3;
  localparam logic [3:0] BR_BUSDISP = 4'd4;
  localparam logic [3:0] BR_CARRY   = 4'd5;

  typedef enum logic [2:0] {
    SRC_REG  = 3'd0,
    SRC_ZERO = 3'd1,
    SRC_NONE = 3'd2,
    SRC_AUX  = 3'd3,
    SRC_MEM  = 3'd4
  } src_e;

  function automatic logic [DW-1:0] rom_word(input logic [AW-1:0] a,
                                             input logic [DW-1:0] seed);
    logic [2*AW-1:0] raw;
    raw = {a, ~a};
    return DW'(raw) ^ seed;
  endfunction

  function automatic logic t_takes_alu(input logic [3:0] f);
    return (f == 4'd0) || (f == 4'd2) || (f == 4'd5) || (f == 4'd6) ||
           (f == 4'd10) || (f == 4'd11) || (f == 4'd12);
  endfunction
endpackage

// File: rtl/mcb_const_rom.sv
module mcb_const_rom #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter logic [DW-1:0] SEED = 16'h3C5A
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] table_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign table_q[i] = mcb_pkg::rom_word(AW'(i), SEED);
  end

  assign data = table_q[addr];
endmodule

// File: rtl/mcb_bus_src.sv
module mcb_bus_src #(
  parameter int DW  = 16,
  parameter int BSW = 3
) (
  input  logic [BSW-1:0] bs,
  input  logic           const_fn,
  input  logic [DW-1:0]  rf_data,
  input  logic [DW-1:0]  md_data,
  input  logic [DW-1:0]  aux_data,
  input  logic [DW-1:0]  rom_data,
  output logic [DW-1:0]  bus
);
  import mcb_pkg::*;
  logic [DW-1:0] src;
  logic          mask_en;

  always_comb begin
    if (const_fn) begin
      src = '1;
    end else begin
      unique case (bs)
        BSW'(SRC_REG):  src = rf_data;
        BSW'(SRC_ZERO): src = '0;
        BSW'(SRC_NONE): src = '1;
        BSW'(SRC_MEM):  src = md_data;
        default:        src = aux_data;
      endcase
    end
  end

  assign mask_en = const_fn || (bs > BSW'(4));
  assign bus     = mask_en ? (src & rom_data) : src;
endmodule

// File: rtl/mcb_branch.sv
module mcb_branch #(
  parameter int DW = 16,
  parameter int NW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall,
  input  logic [3:0]    f2,
  input  logic [DW-1:0] bus,
  input  logic [DW-1:0] shift_res,
  input  logic          carry_q,
  input  logic [NW-1:0] next_fld,
  output logic [NW-1:0] mod_q,
  output logic [NW-1:0] upc
);
  import mcb_pkg::*;
  logic [NW-1:0] mod_d;

  always_comb begin
    mod_d = '0;
    unique case (f2)
      BR_BUSZERO: mod_d[0] = (bus == '0);
      BR_SHNEG:   mod_d[0] = shift_res[DW-1];
      BR_SHZERO:  mod_d[0] = (shift_res == '0);
      BR_BUSDISP: mod_d    = bus[NW-1:0];
      BR_CARRY:   mod_d[0] = carry_q;
      default:    mod_d    = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         mod_q <= '0;
    else if (!stall) mod_q <= mod_d;
  end

  assign upc = next_fld | mod_q;
endmodule

// File: rtl/mcb_bus_branch.sv
module mcb_bus_branch #(
  parameter int DW  = 16,
  parameter int NW  = 10,
  parameter int RSW = 5,
  parameter int BSW = 3,
  parameter logic [DW-1:0] SEED = 16'h3C5A
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           stall,
  input  logic [BSW-1:0] bs,
  input  logic [3:0]     f1,
  input  logic [3:0]     f2,
  input  logic [RSW-1:0] rsel,
  input  logic           rsel_alt_en,
  input  logic [1:0]     rsel_alt,
  input  logic [3:0]     aluf,
  input  logic           ld_t,
  input  logic           ld_l,
  input  logic [NW-1:0]  next_fld,
  input  logic [DW-1:0]  rf_data,
  input  logic [DW-1:0]  md_data,
  input  logic [DW-1:0]  aux_data,
  input  logic [DW-1:0]  alu_res,
  input  logic           alu_cout,
  input  logic [DW-1:0]  shift_res,
  output logic [RSW-1:0] rf_addr,
  output logic [DW-1:0]  bus,
  output logic [NW-1:0]  upc,
  output logic [DW-1:0]  t_q,
  output logic [DW-1:0]  l_q,
  output logic [DW-1:0]  m_q,
  output logic           carry_q,
  output logic [NW-1:0]  mod_q
);
  import mcb_pkg::*;
  localparam int AW = RSW + BSW;

  logic [DW-1:0] rom_data;
  logic          const_fn;

  assign const_fn = (f1 == FN_CONST) || (f2 == FN_CONST);
  assign rf_addr  = rsel_alt_en ? {rsel[RSW-1:2], rsel_alt} : rsel;

  mcb_const_rom #(.AW(AW), .DW(DW), .SEED(SEED)) u_rom (
    .addr ({rsel, bs}),
    .data (rom_data)
  );

  mcb_bus_src #(.DW(DW), .BSW(BSW)) u_src (
    .bs       (bs),
    .const_fn (const_fn),
    .rf_data  (rf_data),
    .md_data  (md_data),
    .aux_data (aux_data),
    .rom_data (rom_data),
    .bus      (bus)
  );

  mcb_branch #(.DW(DW), .NW(NW)) u_br (
    .clk       (clk),
    .rst       (rst),
    .stall     (stall),
    .f2        (f2),
    .bus       (bus),
    .shift_res (shift_res),
    .carry_q   (carry_q),
    .next_fld  (next_fld),
    .mod_q     (mod_q),
    .upc       (upc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      t_q     <= '0;
      l_q     <= '0;
      m_q     <= '0;
      carry_q <= 1'b0;
    end else if (!stall) begin
      if (ld_t) t_q <= t_takes_alu(aluf) ? alu_res : bus;
      if (ld_l) begin
        l_q     <= alu_res;
        m_q     <= alu_res;
        carry_q <= alu_cout;
      end
    end
  end
endmodule

// File: rtl/mcb_checker.sv
module mcb_checker (
  input logic        clk,
  input logic        rst,
  input logic        stall,
  input logic [2:0]  bs,
  input logic [3:0]  f1,
  input logic [3:0]  f2,
  input logic [4:0]  rsel,
  input logic        ld_l,
  input logic        ld_t,
  input logic [15:0] alu_res,
  input logic [15:0] bus,
  input logic [15:0] t_q,
  input logic [15:0] l_q,
  input logic [15:0] m_q,
  input logic        carry_q,
  input logic [9:0]  mod_q
);
  logic no_const;
  assign no_const = (f1 != 4'd7) && (f2 != 4'd7);

  assert_zero_source_R1: assert property (@(posedge clk) disable iff (rst)
    (no_const && bs == 3'd1) |-> (bus == 16'h0000));

  assert_mask_subset_R3: assert property (@(posedge clk) disable iff (rst)
    (bs > 3'd4) |-> ((bus & ~mcb_pkg::rom_word({rsel, bs}, 16'h3C5A)) == 16'h0000));

  assert_dispatch_R6: assert property (@(posedge clk) disable iff (rst)
    (!stall && f2 == 4'd4) |=> (mod_q == $past(bus[9:0])));

  assert_carry_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!ld_l || stall) |=> $stable(carry_q));

  assert_l_m_load_R8: assert property (@(posedge clk) disable iff (rst)
    (ld_l && !stall) |=> (l_q == $past(alu_res) && m_q == $past(alu_res)));

  assert_after_reset_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mod_q == 10'd0 && t_q == 16'h0000 && !carry_q));

  assert_stall_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (stall && !$past(rst)) |=> ($stable(t_q) && $stable(l_q) && $stable(mod_q)));

  assert_t_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!ld_t) |=> $stable(t_q));
endmodule

bind mcb_bus_branch mcb_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .stall   (stall),
  .bs      (bs),
  .f1      (f1),
  .f2      (f2),
  .rsel    (rsel),
  .ld_l    (ld_l),
  .ld_t    (ld_t),
  .alu_res (alu_res),
  .bus     (bus),
  .t_q     (t_q),
  .l_q     (l_q),
  .m_q     (m_q),
  .carry_q (carry_q),
  .mod_q   (mod_q)
);

// File: tb/mcb_bus_branch_test.sv
`timescale 1ns/1ps
module mcb_bus_branch_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stall = 1'b0;
  logic [2:0] bs = '0;
  logic [3:0] f1 = '0, f2 = '0, aluf = '0;
  logic [4:0] rsel = '0;
  logic rsel_alt_en = 1'b0;
  logic [1:0] rsel_alt = '0;
  logic ld_t = 1'b0, ld_l = 1'b0, alu_cout = 1'b0;
  logic [9:0] next_fld = '0;
  logic [15:0] rf_data = '0, md_data = '0, aux_data = '0, alu_res = '0, shift_res = '0;
  logic [4:0] rf_addr;
  logic [15:0] bus, t_q, l_q, m_q;
  logic [9:0] upc, mod_q;
  logic carry_q;

  int errors = 0;
  int checks = 0;

  // model state
  logic [15:0] e_t = '0, e_l = '0, e_m = '0;
  logic e_c = 1'b0;
  logic [9:0] e_mod = '0;
  string reg_tag = "R11";
  string mod_tag = "R11";

  always #2.5 clk = ~clk;

  mcb_bus_branch uut (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crom(input logic [4:0] r, input logic [2:0] b);
    logic [7:0] a;
    a = {r, b};
    return {a, ~a} ^ 16'h3C5A;
  endfunction

  // expected bus and which requirement it exercises
  function automatic logic [15:0] exp_bus(output string tag);
    logic [15:0] v;
    if (f1 == 4'd7 || f2 == 4'd7) begin
      tag = "R2";
      return crom(rsel, bs);
    end
    tag = "R1";
    case (bs)
      3'd0: v = rf_data;
      3'd1: v = 16'h0000;
      3'd2: v = 16'hFFFF;
      3'd3: v = aux_data;
      3'd4: v = md_data;
      default: begin v = aux_data & crom(rsel, bs); tag = "R3"; end
    endcase
    return v;
  endfunction

  task automatic compare_now();
    string bt;
    logic [15:0] eb;
    eb = exp_bus(bt);
    chk(bt, "bus", bus, eb);
    chk("R4", "rf_addr", rf_addr, rsel_alt_en ? {rsel[4:2], rsel_alt} : rsel);
    chk("R10", "upc", upc, next_fld | e_mod);
    chk(reg_tag == "R11" ? "R11" : (reg_tag == "R12" ? "R12" : "R9"), "t", t_q, e_t);
    chk(reg_tag == "R11" ? "R11" : (reg_tag == "R12" ? "R12" : "R8"), "l", l_q, e_l);
    chk(reg_tag == "R11" ? "R11" : (reg_tag == "R12" ? "R12" : "R8"), "m", m_q, e_m);
    chk(reg_tag == "R11" ? "R11" : (reg_tag == "R12" ? "R12" : "R7"), "carry", carry_q, e_c);
    chk(mod_tag, "mod", mod_q, e_mod);
  endtask

  // advance model across the rising edge
  task automatic step();
    string bt;
    logic [15:0] eb;
    logic [9:0] nm;
    eb = exp_bus(bt);
    if (rst) begin
      e_t = '0; e_l = '0; e_m = '0; e_c = 1'b0; e_mod = '0;
      reg_tag = "R11"; mod_tag = "R11";
    end else if (stall) begin
      reg_tag = "R12"; mod_tag = "R12";
    end else begin
      nm = '0;
      mod_tag = "R10";
      if (f2 == 4'd1) begin nm = {9'd0, eb == 16'h0}; mod_tag = "R5"; end
      if (f2 == 4'd2) begin nm = {9'd0, shift_res[15]}; mod_tag = "R5"; end
      if (f2 == 4'd3) begin nm = {9'd0, shift_res == 16'h0}; mod_tag = "R5"; end
      if (f2 == 4'd4) begin nm = eb[9:0]; mod_tag = "R6"; end
      if (f2 == 4'd5) begin nm = {9'd0, e_c}; mod_tag = "R7"; end
      if (ld_t) begin
        case (aluf)
          4'd0, 4'd2, 4'd5, 4'd6, 4'd10, 4'd11, 4'd12: e_t = alu_res;
          default: e_t = eb;
        endcase
      end
      if (ld_l) begin e_l = alu_res; e_m = alu_res; e_c = alu_cout; end
      e_mod = nm;
      reg_tag = "R9";
    end
    @(posedge clk);
  endtask

  task automatic cycle();
    @(negedge clk);
    #1;
    compare_now();
    step();
  endtask

  task automatic drive_random();
    int k;
    k = $urandom_range(0, 15);
    stall = ($urandom_range(0, 7) == 0);
    bs = 3'($urandom);
    f1 = ($urandom_range(0, 9) == 0) ? 4'd7 : 4'($urandom_range(0, 6));
    f2 = 4'($urandom_range(0, 7));
    rsel = 5'($urandom);
    rsel_alt_en = $urandom_range(0, 1) == 1;
    rsel_alt = 2'($urandom);
    aluf = 4'($urandom);
    ld_t = $urandom_range(0, 1) == 1;
    ld_l = $urandom_range(0, 1) == 1;
    next_fld = 10'($urandom) & 10'h3F0;
    rf_data = (k < 3) ? 16'h0 : 16'($urandom);
    md_data = 16'($urandom);
    aux_data = 16'($urandom);
    alu_res = 16'($urandom);
    alu_cout = $urandom_range(0, 1) == 1;
    case ($urandom_range(0, 2))
      0: shift_res = {e_l[14:0], 1'b0};
      1: shift_res = e_l;
      default: shift_res = 16'h0;
    endcase
  endtask

  task automatic set_quiet();
    stall = 0; bs = 3'd2; f1 = 0; f2 = 0; ld_t = 0; ld_l = 0; rsel_alt_en = 0;
    next_fld = 10'h100; aluf = 4'd1; alu_cout = 0;
  endtask

  initial begin : watchdog
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    set_quiet();
    rst = 1;
    repeat (3) cycle();
    rst = 0;
    set_quiet();
    cycle();  // R11 reset state compared here

    // R7 directed: latch carry=1, then a non-loading cycle with cout=0, then dispatch on carry
    @(negedge clk); set_quiet(); ld_l = 1; alu_cout = 1; alu_res = 16'h8001; #1; compare_now(); step();
    @(negedge clk); set_quiet(); f2 = 4'd5; alu_cout = 0; #1; compare_now(); step();
    @(negedge clk); set_quiet(); #1; compare_now(); step();
    // R2 directed: constant code with load-R source still yields the constant
    @(negedge clk); set_quiet(); f1 = 4'd7; bs = 3'd1; rsel = 5'h13; #1; compare_now(); step();
    // R4 directed: override changes rf_addr but not the constant address
    @(negedge clk); set_quiet(); f2 = 4'd7; bs = 3'd6; rsel = 5'h0A; rsel_alt_en = 1; rsel_alt = 2'd3;
    #1; compare_now(); step();
    // R6 directed: bus dispatch from memory data
    @(negedge clk); set_quiet(); bs = 3'd4; md_data = 16'hFEDC; f2 = 4'd4; #1; compare_now(); step();
    // R12 directed: stall during a load keeps everything
    @(negedge clk); set_quiet(); stall = 1; ld_t = 1; ld_l = 1; f2 = 4'd4; bs = 3'd2; #1; compare_now(); step();
    @(negedge clk); set_quiet(); #1; compare_now(); step();

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      drive_random();
      #1;
      compare_now();
      step();
    end
    @(negedge clk); set_quiet(); #1; compare_now();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule